// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the register bank that sits between a host and up to eight DMA channel engines. The host reaches it through a plain 32-bit port with separate read and write strobes. The bank holds three kinds of state. Shared control words pack every channel's mode, direction, interrupt enable and start request at fixed per-channel strides. A status word combines each engine's live state with per-channel interrupt and error flags. Each channel also has a four-word descriptor window holding its device address, memory address, size and next-link values.

Every control field and window word drives the channel engines directly. A start request is held until the engine accepts it, and it clears itself then. The engines report completion and error events, and these set flags that the host clears by writing ones. One registered interrupt line covers every channel that has both its flag and its enable set.

Top module: `dma_csr_bank`

## Requirements
- R1: After a synchronous reset, every register, `rdata`, `irq` and every channel output is zero.
- R2: Word addresses, with the two low address bits ignored:
  - control-0 is at 0x00, control-1 (a general read/write word) at 0x04, control-2 at 0x08 and status-0 at 0x10.
  - 0x0C, 0x14, 0x18, 0x1C and every address past the last channel window read as zero and ignore writes.
  - A read presents its data on `rdata` in the cycle after `rd_en`.
- R3: Control-0 gives channel c the nibble at bit 4c:
  - Bits 1:0 are the mode (0 off, 1 chained, 2 single), shown on `ch_mode[2c+1:2c]`.
  - Bit 2 is the direction (1 memory-to-device), shown on `ch_dir[c]`.
  - Bit 3 reads as zero.
- R4: Control-2 bit c is channel c's interrupt enable, shown on `ch_irq_en[c]`.
- R5: Writing 1 to control-2 bit 8+c raises `ch_start[c]` in the next cycle only when `ch_state[2c+1:2c]` is 0 (idle). The write is ignored when the channel is not idle. Writing 0 there has no effect.
- R6: A raised start stays set until `ch_accept[c]`, and then it clears itself. After that it reads back as 0.
- R7: Status-0 bits 16+2c..17+2c show `ch_state` for channel c live (0 idle, 1 descriptor read, 2 waiting, 3 transferring). Writes to these bits are ignored.
- R8: `ch_done[c]` sets status-0 bit c (interrupt flag). `ch_err[c]` sets bit c and bit 8+c (error flag). A set wins over a clear in the same cycle.
- R9: Writing 1 to status-0 bit c clears that channel's interrupt flag and its error flag. Writing 1 to bit 8+c clears only the error flag. Zeros leave the flags unchanged.
- R10: An error flag is never set while the matching interrupt flag is clear.
- R11: `irq` is high in the cycle after any channel has both its interrupt flag and its enable set.
- R12: Channel c's window starts at 0x20+16c and holds four read/write words: device address (+0x0), memory address (+0x4), size (+0x8) and next (+0xC). These drive `ch_dev_addr`, `ch_mem_addr`, `ch_size` and `ch_next` at bit 32c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| ch_mode | output | 2*NCH | Per-channel mode fields |
| ch_dir | output | NCH | Per-channel direction |
| ch_irq_en | output | NCH | Per-channel interrupt enable |
| ch_start | output | NCH | Pending start request per channel |
| ch_state | input | 2*NCH | Live engine state per channel |
| ch_done | input | NCH | Completion event per channel |
| ch_err | input | NCH | Error event per channel |
| ch_accept | input | NCH | Engine has taken the start request |
| ch_dev_addr | output | 32*NCH | Window device address words |
| ch_mem_addr | output | 32*NCH | Window memory address words |
| ch_size | output | 32*NCH | Window size words |
| ch_next | output | 32*NCH | Window next-link words |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the following corner cases:
- **Start on a busy channel.** A design that ignored the idle test would raise `ch_start` for a channel still transferring.
- **Start written back as 0.** A design that let a zero cancel a pending start would drop the engine's request.
- **Flag clearing.** Clearing only the interrupt bit must also drop the error flag. Otherwise status-0 would show an orphan error bit.
- **Event and clear in the same cycle.** An event that arrives together with a clear of the same flag must still leave the flag set. Otherwise a completion would be lost.
- **Writes to the live state bits and reserved words.** These must change nothing. A design that stored them would read back stale ones.
- **Last channel's window.** An off-by-one decode would alias the highest window or the first address past it.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned WIN_WORDS = 4;
  localparam int unsigned WIN_BITS  = WORD_W * WIN_WORDS;
  localparam logic [7:0]  WIN_BASE  = 8'h20;

  // word index inside the low 0x20 bytes
  typedef enum logic [2:0] {
    GW_CTL0 = 3'd0,
    GW_CTL1 = 3'd1,
    GW_CTL2 = 3'd2,
    GW_RSV3 = 3'd3,
    GW_STS0 = 3'd4,
    GW_STS1 = 3'd5,
    GW_RSV6 = 3'd6,
    GW_RSV7 = 3'd7
  } gword_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_MOVE  = 2'd3
  } chst_e;

  // packed so that the device address is the lowest word
  typedef struct packed {
    logic [WORD_W-1:0] next;
    logic [WORD_W-1:0] size;
    logic [WORD_W-1:0] mem;
    logic [WORD_W-1:0] dev;
  } win_t;

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 8,
  parameter int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0] addr,
  output logic          sel_ctl0,
  output logic          sel_ctl1,
  output logic          sel_ctl2,
  output logic          sel_sts0,
  output logic          sel_win,
  output logic [CW-1:0] win_ch,
  output logic [1:0]    win_word
);

  localparam int unsigned HW = AW - 4;

  logic [AW-1:0] woff;
  logic [HW-1:0] wslot;
  logic          in_global;
  gword_e        gidx;
  logic          unused_lo;

  assign unused_lo = ^{addr[1:0], woff[1:0]};
  assign in_global = (addr[AW-1:5] == '0);
  assign gidx      = gword_e'(addr[4:2]);
  assign woff      = addr - AW'(WIN_BASE);
  assign wslot     = woff[AW-1:4];

  // R2: reserved words and out-of-range windows select nothing
  always_comb begin
    sel_ctl0 = in_global && (gidx == GW_CTL0);
    sel_ctl1 = in_global && (gidx == GW_CTL1);
    sel_ctl2 = in_global && (gidx == GW_CTL2);
    sel_sts0 = in_global && (gidx == GW_STS0);
    sel_win  = !in_global && (wslot < HW'(NCH));
    win_ch   = wslot[CW-1:0];
    win_word = woff[3:2];
  end

endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl0,
  input  logic [2:0]        ctl0_fld,
  input  logic              wr_ctl2,
  input  logic              ien_bit,
  input  logic              start_bit,
  input  logic              wr_sts0,
  input  logic              clr_irq,
  input  logic              clr_err,
  input  logic [3:0]        wr_win,
  input  logic [WORD_W-1:0] wdata,
  input  logic [1:0]        state,
  input  logic              done,
  input  logic              err,
  input  logic              accept,
  output logic [1:0]        mode,
  output logic              dir,
  output logic              ien,
  output logic              start,
  output logic              irqf,
  output logic              errf,
  output win_t              win
);

  logic [WIN_WORDS-1:0][WORD_W-1:0] words;
  logic idle;

  assign idle = (chst_e'(state) == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= '0;
      dir   <= 1'b0;
      ien   <= 1'b0;
      start <= 1'b0;
      irqf  <= 1'b0;
      errf  <= 1'b0;
    end else begin
      // R3
      if (wr_ctl0) {dir, mode} <= ctl0_fld;
      // R4
      if (wr_ctl2) ien <= ien_bit;
      // R5 R6: held until taken, only armed from idle
      start <= (start & ~accept) | (wr_ctl2 & start_bit & idle);
      // R8 R9 R10: set has priority; clearing the event flag drops the error too
      irqf  <= done | err | (irqf & ~(wr_sts0 & clr_irq));
      errf  <= err | (errf & ~(wr_sts0 & (clr_irq | clr_err)));
    end
  end

  // R12: descriptor window words
  for (genvar w = 0; w < WIN_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)            words[w] <= '0;
      else if (wr_win[w]) words[w] <= wdata;
    end
  end

  assign win = win_t'(words);

endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux
  import dma_csr_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 3
) (
  input  logic                    sel_ctl0,
  input  logic                    sel_ctl1,
  input  logic                    sel_ctl2,
  input  logic                    sel_sts0,
  input  logic                    sel_win,
  input  logic [CW-1:0]           win_ch,
  input  logic [1:0]              win_word,
  input  logic [WORD_W-1:0]       ctl1,
  input  logic [2*NCH-1:0]        mode_v,
  input  logic [NCH-1:0]          dir_v,
  input  logic [NCH-1:0]          ien_v,
  input  logic [NCH-1:0]          start_v,
  input  logic [NCH-1:0]          irqf_v,
  input  logic [NCH-1:0]          errf_v,
  input  logic [2*NCH-1:0]        state_v,
  input  logic [NCH*WIN_BITS-1:0] win_v,
  output logic [WORD_W-1:0]       rd_word
);

  logic [WORD_W-1:0] ctl0_w, ctl2_w, sts0_w, win_w;

  always_comb begin
    ctl0_w = '0;
    ctl2_w = '0;
    sts0_w = '0;
    for (int c = 0; c < NCH; c++) begin
      ctl0_w[4*c +: 3]      = {dir_v[c], mode_v[2*c +: 2]};
      ctl2_w[c]             = ien_v[c];
      ctl2_w[8+c]           = start_v[c];
      sts0_w[c]             = irqf_v[c];
      sts0_w[8+c]           = errf_v[c];
      sts0_w[16+2*c +: 2]   = state_v[2*c +: 2];
    end
  end

  assign win_w = win_v[{win_ch, win_word, 5'b0} +: WORD_W];

  always_comb begin
    if (sel_ctl0)      rd_word = ctl0_w;
    else if (sel_ctl1) rd_word = ctl1;
    else if (sel_ctl2) rd_word = ctl2_w;
    else if (sel_sts0) rd_word = sts0_w;
    else if (sel_win)  rd_word = win_w;
    else               rd_word = '0;
  end

endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [AW-1:0]         addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     rdata,
  output logic [2*NCH-1:0]      ch_mode,
  output logic [NCH-1:0]        ch_dir,
  output logic [NCH-1:0]        ch_irq_en,
  output logic [NCH-1:0]        ch_start,
  input  logic [2*NCH-1:0]      ch_state,
  input  logic [NCH-1:0]        ch_done,
  input  logic [NCH-1:0]        ch_err,
  input  logic [NCH-1:0]        ch_accept,
  output logic [WORD_W*NCH-1:0] ch_dev_addr,
  output logic [WORD_W*NCH-1:0] ch_mem_addr,
  output logic [WORD_W*NCH-1:0] ch_size,
  output logic [WORD_W*NCH-1:0] ch_next,
  output logic                  irq
);

  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic                    sel_ctl0, sel_ctl1, sel_ctl2, sel_sts0, sel_win;
  logic [CW-1:0]           win_ch;
  logic [1:0]              win_word;
  logic [WORD_W-1:0]       ctl1_q;
  logic [WORD_W-1:0]       rd_word;
  logic [NCH-1:0]          irqf_v, errf_v;
  logic [NCH*WIN_BITS-1:0] win_v;

  dma_csr_decode #(.NCH(NCH), .AW(AW), .CW(CW)) i_decode (
    .addr     (addr),
    .sel_ctl0 (sel_ctl0),
    .sel_ctl1 (sel_ctl1),
    .sel_ctl2 (sel_ctl2),
    .sel_sts0 (sel_sts0),
    .sel_win  (sel_win),
    .win_ch   (win_ch),
    .win_word (win_word)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [3:0] wr_win_c;
    win_t       win_c;

    assign wr_win_c = (wr_en && sel_win && (win_ch == CW'(c))) ? (4'b0001 << win_word) : 4'b0000;

    dma_csr_chan i_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_ctl0   (wr_en && sel_ctl0),
      .ctl0_fld  (wdata[4*c +: 3]),
      .wr_ctl2   (wr_en && sel_ctl2),
      .ien_bit   (wdata[c]),
      .start_bit (wdata[8+c]),
      .wr_sts0   (wr_en && sel_sts0),
      .clr_irq   (wdata[c]),
      .clr_err   (wdata[8+c]),
      .wr_win    (wr_win_c),
      .wdata     (wdata),
      .state     (ch_state[2*c +: 2]),
      .done      (ch_done[c]),
      .err       (ch_err[c]),
      .accept    (ch_accept[c]),
      .mode      (ch_mode[2*c +: 2]),
      .dir       (ch_dir[c]),
      .ien       (ch_irq_en[c]),
      .start     (ch_start[c]),
      .irqf      (irqf_v[c]),
      .errf      (errf_v[c]),
      .win       (win_c)
    );

    assign ch_dev_addr[WORD_W*c +: WORD_W] = win_c.dev;
    assign ch_mem_addr[WORD_W*c +: WORD_W] = win_c.mem;
    assign ch_size[WORD_W*c +: WORD_W]     = win_c.size;
    assign ch_next[WORD_W*c +: WORD_W]     = win_c.next;
    assign win_v[WIN_BITS*c +: WIN_BITS]   = win_c;
  end

  dma_csr_rdmux #(.NCH(NCH), .CW(CW)) i_rdmux (
    .sel_ctl0 (sel_ctl0),
    .sel_ctl1 (sel_ctl1),
    .sel_ctl2 (sel_ctl2),
    .sel_sts0 (sel_sts0),
    .sel_win  (sel_win),
    .win_ch   (win_ch),
    .win_word (win_word),
    .ctl1     (ctl1_q),
    .mode_v   (ch_mode),
    .dir_v    (ch_dir),
    .ien_v    (ch_irq_en),
    .start_v  (ch_start),
    .irqf_v   (irqf_v),
    .errf_v   (errf_v),
    .state_v  (ch_state),
    .win_v    (win_v),
    .rd_word  (rd_word)
  );

  // R1 R2 R11: general word, registered read data and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl1_q <= '0;
      rdata  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_en && sel_ctl1) ctl1_q <= wdata;
      if (rd_en)             rdata  <= rd_word;
      irq <= |(irqf_v & ch_irq_en);
    end
  end

endmodule

// File: rtl/dma_csr_bank_chk.sv
module dma_csr_bank_chk #(
  parameter int unsigned NCH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [31:0]      rdata,
  input logic [NCH-1:0]   ch_start,
  input logic [2*NCH-1:0] ch_state,
  input logic [NCH-1:0]   ch_accept,
  input logic [NCH-1:0]   ch_done,
  input logic [NCH-1:0]   ch_err,
  input logic [NCH-1:0]   ch_irq_en,
  input logic [NCH-1:0]   irqf_v,
  input logic [NCH-1:0]   errf_v,
  input logic             irq
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ch_start == '0 && irq == 1'b0 && rdata == '0));

  // R10
  err_needs_irq_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (errf_v & ~irqf_v) == '0);

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    irq == $past(|(irqf_v & ch_irq_en)));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
      $rose(ch_start[c]) |-> ($past(ch_state[2*c +: 2]) == 2'd0));

    // R6
    start_drop_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
      (ch_start[c] && ch_accept[c] && !wr_en) |=> !ch_start[c]);

    // R8
    event_set_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
      (ch_done[c] || ch_err[c]) |=> irqf_v[c]);
  end

endmodule

bind dma_csr_bank dma_csr_bank_chk #(.NCH(NCH)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rdata     (rdata),
  .ch_start  (ch_start),
  .ch_state  (ch_state),
  .ch_accept (ch_accept),
  .ch_done   (ch_done),
  .ch_err    (ch_err),
  .ch_irq_en (ch_irq_en),
  .irqf_v    (irqf_v),
  .errf_v    (errf_v),
  .irq       (irq)
);

// File: tb/test_dma_csr_bank.sv
module test_dma_csr_bank;

  localparam int unsigned NCH = 8;
  localparam int unsigned AW  = 8;
  localparam int unsigned NV  = 19;

  logic              clk = 1'b0;
  logic              rst;
  logic              wr_en, rd_en;
  logic [AW-1:0]     addr;
  logic [31:0]       wdata, rdata;
  logic [2*NCH-1:0]  ch_mode;
  logic [NCH-1:0]    ch_dir, ch_irq_en, ch_start;
  logic [2*NCH-1:0]  ch_state;
  logic [NCH-1:0]    ch_done, ch_err, ch_accept;
  logic [32*NCH-1:0] ch_dev_addr, ch_mem_addr, ch_size, ch_next;
  logic              irq;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dma_csr_bank #(.NCH(NCH), .AW(AW)) i_dma_csr_bank (
    .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
    .wdata (wdata), .rdata (rdata), .ch_mode (ch_mode), .ch_dir (ch_dir),
    .ch_irq_en (ch_irq_en), .ch_start (ch_start), .ch_state (ch_state),
    .ch_done (ch_done), .ch_err (ch_err), .ch_accept (ch_accept),
    .ch_dev_addr (ch_dev_addr), .ch_mem_addr (ch_mem_addr),
    .ch_size (ch_size), .ch_next (ch_next), .irq (irq)
  );

  // {is_write, address, data or expected read}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h04, 32'hCAFEF00D},
    {1'b0, 8'h04, 32'hCAFEF00D},
    {1'b1, 8'h20, 32'h11111111},
    {1'b1, 8'h2C, 32'h22222222},
    {1'b1, 8'h98, 32'h33333333},
    {1'b0, 8'h20, 32'h11111111},
    {1'b0, 8'h2C, 32'h22222222},
    {1'b0, 8'h98, 32'h33333333},
    {1'b0, 8'h24, 32'h00000000},
    {1'b1, 8'h0C, 32'hFFFFFFFF},
    {1'b0, 8'h0C, 32'h00000000},
    {1'b1, 8'h14, 32'hFFFFFFFF},
    {1'b0, 8'h14, 32'h00000000},
    {1'b1, 8'hA0, 32'hFFFFFFFF},
    {1'b0, 8'hA0, 32'h00000000},
    {1'b1, 8'h1C, 32'hFFFFFFFF},
    {1'b0, 8'h1C, 32'h00000000},
    {1'b0, 8'h2F, 32'h22222222},
    {1'b0, 8'h04, 32'hCAFEF00D}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle_cycle;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    ch_state = '0; ch_done = '0; ch_err = '0; ch_accept = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 start", {24'b0, ch_start}, 32'h0);
    chk("R1 mode", {16'b0, ch_mode}, 32'h0);
    rd(8'h10, v); chk("R1 status0", v, 32'h0);

    // R2 R12 vector walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][39:32], v);
        chk($sformatf("R2/R12 vector %0d", i), v, VEC[i][31:0]);
      end
    end
    chk("R12 ch0 next out", ch_next[31:0], 32'h22222222);
    chk("R12 ch7 size out", ch_size[7*32 +: 32], 32'h33333333);
    chk("R12 ch0 dev out", ch_dev_addr[31:0], 32'h11111111);

    // R3 control-0 fields
    wr(8'h00, 32'hFFFFFFFF);
    rd(8'h00, v); chk("R3 spare bit reads 0", v, 32'h77777777);
    chk("R3 mode all", {16'b0, ch_mode}, 32'h0000FFFF);
    wr(8'h00, 32'h00000621);
    chk("R3 mode", {16'b0, ch_mode}, 32'h00000029);
    chk("R3 dir", {24'b0, ch_dir}, 32'h00000004);
    rd(8'h00, v); chk("R3 readback", v, 32'h00000621);

    // R4 enables
    wr(8'h08, 32'h000000A5);
    chk("R4 enables", {24'b0, ch_irq_en}, 32'h000000A5);
    rd(8'h08, v); chk("R4 readback", v, 32'h000000A5);

    // R5 R6 start on idle channel and self-clear
    wr(8'h08, 32'h000004A5);
    chk("R5 start raised", {24'b0, ch_start}, 32'h00000004);
    rd(8'h08, v); chk("R5 start readback", v, 32'h000004A5);
    wr(8'h08, 32'h000000A5);
    chk("R5 zero write keeps start", {24'b0, ch_start}, 32'h00000004);
    ch_accept = 8'h04; idle_cycle; ch_accept = '0;
    chk("R6 start cleared", {24'b0, ch_start}, 32'h0);
    rd(8'h08, v); chk("R6 readback zero", v, 32'h000000A5);

    // R5 start on busy channel ignored
    ch_state = 16'h0080;
    wr(8'h08, 32'h000008A5);
    chk("R5 busy start ignored", {24'b0, ch_start}, 32'h0);
    rd(8'h08, v); chk("R5 busy readback", v, 32'h000000A5);

    // R7 live state and write-ignore
    ch_state = 16'hB4E1;
    rd(8'h10, v); chk("R7 live state", v, 32'hB4E10000);
    wr(8'h10, 32'hFFFF0000);
    rd(8'h10, v); chk("R7 state write ignored", v, 32'hB4E10000);
    ch_state = '0;

    // R8 R11 done event and gating by enable
    ch_done = 8'h02; idle_cycle; ch_done = '0;
    rd(8'h10, v); chk("R8 done flag", v, 32'h00000002);
    chk("R11 masked irq", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h000000A7);
    idle_cycle;
    chk("R11 irq asserted", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h00000002);
    idle_cycle;
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);
    rd(8'h10, v); chk("R9 flag cleared", v, 32'h0);

    // R8 R9 R10 error flag handling
    ch_err = 8'h10; idle_cycle; ch_err = '0;
    rd(8'h10, v); chk("R8 error sets both", v, 32'h00001010);
    wr(8'h10, 32'h00001000);
    rd(8'h10, v); chk("R9 clear error only", v, 32'h00000010);
    ch_err = 8'h10; idle_cycle; ch_err = '0;
    wr(8'h10, 32'h00000010);
    rd(8'h10, v); chk("R10 clearing event drops error", v, 32'h0);

    // R8 set wins over same-cycle clear
    ch_err = 8'h20;
    wr(8'h10, 32'h00002020);
    ch_err = '0;
    rd(8'h10, v); chk("R8 set beats clear", v, 32'h00002020);
    chk("R11 irq from enabled error", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h00000020);
    rd(8'h10, v); chk("R9 final clear", v, 32'h0);

    // R1 reset in mid-run
    rst = 1'b1; idle_cycle; rst = 1'b0;
    chk("R1 enables cleared", {24'b0, ch_irq_en}, 32'h0);
    chk("R1 irq cleared", {31'b0, irq}, 32'h0);
    rd(8'h20, v); chk("R1 window cleared", v, 32'h0);
    rd(8'h04, v); chk("R1 control1 cleared", v, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule